// File: doc/BRIEF.md
# Microprogrammed control sequencer

This block is the control unit of a small processor with two data registers, one ALU and a single condition flag. Every processor cycle is driven by a micro-instruction read from a control store. A micro-program counter addresses that store. Each micro-word holds the datapath strobes and a sequencing action. The action either restarts at the instruction-fetch routine, steps to the next micro-word, or jumps to the routine that a mapping table picks from the instruction register. For the extended-operation opcode, the table uses the instruction's address field as well.

Each micro-step takes two clock cycles, tracked by a phase bit.

- Level strobes are memory read and write, the select lines, the ALU operation and program read. They are valid for the whole step.
- Load pulses for the x, y, instruction and PC registers and for the flag occur only in the second cycle, so the registers capture values that have had a full cycle to settle.
- The sequencing action takes effect at the end of the second cycle.

The conditional PC load of the branch routines is gated with the flag input during that second cycle. The block has no data stream: it reads the instruction register fields and the flag, and drives plain control pins.

Top module: `ucode_sequencer`

## Requirements
- R1: A synchronous reset places the sequencer at the first cycle of fetch step one. In that cycle prog_rd is 1 and every other strobe is 0. This holds even when the reset arrives in the middle of a routine.
- R2: Every micro-step lasts exactly two cycles. mem_rd, mem_wr, x_from_alu, alu_sel, prog_rd and pc_from_ads keep one value across both cycles. x_load, y_load, ir_load, pc_load and flag_load are asserted only in the second cycle.
- R3: Fetch step one asserts prog_rd in both cycles and ir_load in its second cycle, then proceeds to fetch step two.
- R4: Fetch step two asserts pc_load in its second cycle with pc_from_ads at 0 (PC+1). It then decodes ir_op and ir_ads into the start of a routine.
- R5: Opcodes are: 0 load x, 1 load y, 2 store x, 3 jump, 4 jump-if-true, 5 jump-if-false, 6 extended ALU operation. Load x asserts mem_rd with x_from_alu at 0 and pulses x_load. Load y asserts mem_rd and pulses y_load.
- R6: Store x asserts mem_wr and no load pulse. Jump asserts pc_from_ads and pulses pc_load. mem_rd and mem_wr are never asserted together.
- R7: Jump-if-true asserts pc_from_ads and pulses pc_load only if alu_flag is 1 in the second cycle. Jump-if-false does the same only if alu_flag is 0.
- R8: With opcode 6 and an ir_ads value k from 0 to 7, alu_sel equals k in both cycles. The codes are 0 add, 1 sub, 2 inc, 3 dec, 4 and, 5 or, 6 eq, 7 eqz. For k below 6, x_from_alu is 1 and x_load is pulsed. For k of 6 or 7, flag_load is pulsed and x_load is not.
- R9: Every instruction routine is a single step and is followed by fetch step one.
- R10: Opcodes 7 to 15, and opcode 6 with ir_ads above 7, decode straight to fetch step one with no routine step.
- R11: Once decoded, the running routine is unaffected by later changes of ir_op and ir_ads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_op | input | OPW | Opcode field of the instruction register |
| ir_ads | input | ADW | Address field of the instruction register |
| alu_flag | input | 1 | Current condition flag |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| x_load | output | 1 | Load pulse for register x |
| y_load | output | 1 | Load pulse for register y |
| x_from_alu | output | 1 | x input select: 1 ALU result, 0 memory |
| alu_sel | output | 3 | ALU operation code |
| prog_rd | output | 1 | Program memory read |
| ir_load | output | 1 | Load pulse for the instruction register |
| pc_load | output | 1 | Load pulse for the PC |
| pc_from_ads | output | 1 | PC input select: 1 address field, 0 PC+1 |
| flag_load | output | 1 | Load pulse for the flag |

## Verification
The branch routines get a flag that changes between the two cycles of the step. A design that sampled the flag in the wrong cycle would branch on a stale value. The instruction fields are scrambled once decode is done. A sequencer that kept decoding would switch routines partway through. Undefined opcodes and extended operations with an out-of-range field are checked for a direct return to fetch, which catches a stray routine step. A reset during a routine must land exactly on fetch step one, and every compare operation must leave x untouched while loading the flag.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UAW  = 4;
  localparam int ALUW = 3;

  localparam int OP_LDX = 0;
  localparam int OP_LDY = 1;
  localparam int OP_STX = 2;
  localparam int OP_JMP = 3;
  localparam int OP_JT  = 4;
  localparam int OP_JF  = 5;
  localparam int OP_XOP = 6;

  localparam logic [UAW-1:0] U_FETCH0 = UAW'(0);
  localparam logic [UAW-1:0] U_FETCH1 = UAW'(1);
  localparam logic [UAW-1:0] U_LDX    = UAW'(2);
  localparam logic [UAW-1:0] U_LDY    = UAW'(3);
  localparam logic [UAW-1:0] U_STX    = UAW'(4);
  localparam logic [UAW-1:0] U_JMP    = UAW'(5);
  localparam logic [UAW-1:0] U_JT     = UAW'(6);
  localparam logic [UAW-1:0] U_JF     = UAW'(7);
  localparam logic [UAW-1:0] U_ALU0   = UAW'(8);

  localparam int ALU_FIRST_CMP = 6;

  typedef enum logic [1:0] {
    SEQ_FETCH  = 2'd0,
    SEQ_NEXT   = 2'd1,
    SEQ_DECODE = 2'd2
  } seq_e;

  typedef enum logic [1:0] {
    PCC_NEVER  = 2'd0,
    PCC_ALWAYS = 2'd1,
    PCC_IFT    = 2'd2,
    PCC_IFF    = 2'd3
  } pcc_e;

  typedef struct packed {
    logic            rd;
    logic            wr;
    logic            ld_x;
    logic            ld_y;
    logic            x_alu;
    logic [ALUW-1:0] alu_op;
    logic            prog_rd;
    logic            ld_ir;
    pcc_e            pc_cond;
    logic            pc_ads;
    logic            flag_wr;
    seq_e            seq;
  } uword_t;
endpackage

// File: rtl/ucode_map.sv
module ucode_map
  import ucode_pkg::*;
#(
  parameter int OPW = 4,
  parameter int ADW = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [ADW-1:0] ads,
  output logic [UAW-1:0] start
);
  localparam logic [ADW-1:0] ALU_CODES = ADW'(1 << ALUW);

  always_comb begin
    start = U_FETCH0;
    case (op)
      OPW'(OP_LDX): start = U_LDX;
      OPW'(OP_LDY): start = U_LDY;
      OPW'(OP_STX): start = U_STX;
      OPW'(OP_JMP): start = U_JMP;
      OPW'(OP_JT):  start = U_JT;
      OPW'(OP_JF):  start = U_JF;
      OPW'(OP_XOP): begin
        if (ads < ALU_CODES) start = U_ALU0 + UAW'(ads[ALUW-1:0]);
      end
      default: start = U_FETCH0;
    endcase
  end
endmodule

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
(
  input  logic [UAW-1:0] addr,
  output uword_t         word
);
  always_comb begin
    word = '0;
    word.seq = SEQ_FETCH;
    case (addr)
      U_FETCH0: begin
        word.prog_rd = 1'b1;
        word.ld_ir   = 1'b1;
        word.seq     = SEQ_NEXT;
      end
      U_FETCH1: begin
        word.pc_cond = PCC_ALWAYS;
        word.seq     = SEQ_DECODE;
      end
      U_LDX: begin
        word.rd   = 1'b1;
        word.ld_x = 1'b1;
      end
      U_LDY: begin
        word.rd   = 1'b1;
        word.ld_y = 1'b1;
      end
      U_STX: word.wr = 1'b1;
      U_JMP: begin
        word.pc_ads  = 1'b1;
        word.pc_cond = PCC_ALWAYS;
      end
      U_JT: begin
        word.pc_ads  = 1'b1;
        word.pc_cond = PCC_IFT;
      end
      U_JF: begin
        word.pc_ads  = 1'b1;
        word.pc_cond = PCC_IFF;
      end
      default: begin
        if (addr >= U_ALU0) begin
          word.alu_op = addr[ALUW-1:0];
          if (addr[ALUW-1:0] < ALUW'(ALU_FIRST_CMP)) begin
            word.x_alu = 1'b1;
            word.ld_x  = 1'b1;
          end else begin
            word.flag_wr = 1'b1;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/ucode_upc.sv
module ucode_upc
  import ucode_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  seq_e           seq,
  input  logic [UAW-1:0] map_addr,
  output logic [UAW-1:0] upc,
  output logic           phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      upc   <= U_FETCH0;
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        case (seq)
          SEQ_NEXT:   upc <= upc + UAW'(1);
          SEQ_DECODE: upc <= map_addr;
          default:    upc <= U_FETCH0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int OPW = 4,
  parameter int ADW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  ir_op,
  input  logic [ADW-1:0]  ir_ads,
  input  logic            alu_flag,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            x_load,
  output logic            y_load,
  output logic            x_from_alu,
  output logic [ALUW-1:0] alu_sel,
  output logic            prog_rd,
  output logic            ir_load,
  output logic            pc_load,
  output logic            pc_from_ads,
  output logic            flag_load
);
  logic [UAW-1:0] upc;
  logic [UAW-1:0] map_addr;
  logic           phase;
  uword_t         word;
  logic           pc_ok;

  ucode_map #(.OPW(OPW), .ADW(ADW)) u_map (
    .op(ir_op), .ads(ir_ads), .start(map_addr)
  );

  ucode_store u_store (.addr(upc), .word(word));

  ucode_upc u_upc (
    .clk(clk), .rst(rst), .seq(word.seq), .map_addr(map_addr),
    .upc(upc), .phase(phase)
  );

  always_comb begin
    case (word.pc_cond)
      PCC_ALWAYS: pc_ok = 1'b1;
      PCC_IFT:    pc_ok = alu_flag;
      PCC_IFF:    pc_ok = ~alu_flag;
      default:    pc_ok = 1'b0;
    endcase
  end

  assign mem_rd      = word.rd;
  assign mem_wr      = word.wr;
  assign x_from_alu  = word.x_alu;
  assign alu_sel     = word.alu_op;
  assign prog_rd     = word.prog_rd;
  assign pc_from_ads = word.pc_ads;
  assign x_load      = phase & word.ld_x;
  assign y_load      = phase & word.ld_y;
  assign ir_load     = phase & word.ld_ir;
  assign pc_load     = phase & pc_ok;
  assign flag_load   = phase & word.flag_wr;
endmodule

// File: rtl/ucode_seq_checker.sv
module ucode_seq_checker
  import ucode_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [UAW-1:0]  upc,
  input logic            phase,
  input logic            alu_flag,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            x_load,
  input logic            y_load,
  input logic            x_from_alu,
  input logic [ALUW-1:0] alu_sel,
  input logic            prog_rd,
  input logic            ir_load,
  input logic            pc_load,
  input logic            pc_from_ads,
  input logic            flag_load
);
  logic any_load;
  assign any_load = x_load | y_load | ir_load | pc_load | flag_load;

  assert_load_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    any_load |=> !any_load);

  assert_levels_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable({mem_rd, mem_wr, x_from_alu, alu_sel, prog_rd, pc_from_ads}));

  assert_fetch_advance_R3: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (upc == U_FETCH1 && !phase));

  assert_mem_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_jt_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (upc == U_JT && !alu_flag) |-> !pc_load);

  assert_jf_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (upc == U_JF && alu_flag) |-> !pc_load);

  assert_cmp_keeps_x_R8: assert property (@(posedge clk) disable iff (rst)
    flag_load |-> !x_load);

  assert_return_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (phase && upc >= U_LDX) |=> (upc == U_FETCH0));
endmodule

bind ucode_sequencer ucode_seq_checker u_chk (
  .clk(clk), .rst(rst), .upc(upc), .phase(phase), .alu_flag(alu_flag),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .x_load(x_load), .y_load(y_load),
  .x_from_alu(x_from_alu), .alu_sel(alu_sel), .prog_rd(prog_rd),
  .ir_load(ir_load), .pc_load(pc_load), .pc_from_ads(pc_from_ads),
  .flag_load(flag_load)
);

// File: tb/ucode_sequencer_test.sv
module ucode_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ir_op = '0;
  logic [7:0] ir_ads = '0;
  logic       alu_flag = 1'b0;
  logic mem_rd, mem_wr, x_load, y_load, x_from_alu, prog_rd;
  logic ir_load, pc_load, pc_from_ads, flag_load;
  logic [2:0] alu_sel;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ucode_sequencer #(.OPW(4), .ADW(8)) uut (
    .clk(clk), .rst(rst), .ir_op(ir_op), .ir_ads(ir_ads), .alu_flag(alu_flag),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .x_load(x_load), .y_load(y_load),
    .x_from_alu(x_from_alu), .alu_sel(alu_sel), .prog_rd(prog_rd),
    .ir_load(ir_load), .pc_load(pc_load), .pc_from_ads(pc_from_ads),
    .flag_load(flag_load)
  );

  function automatic bit is_valid(logic [3:0] op, logic [7:0] ads);
    return (op < 4'd6) || (op == 4'd6 && ads < 8'd8);
  endfunction

  // kind: 0 fetch step one, 1 fetch step two, 2 routine step
  function automatic logic [12:0] expect_word(int kind, bit ph, logic [3:0] op,
                                              logic [7:0] ads, bit flg);
    logic rd = 0, wr = 0, lx = 0, ly = 0, xa = 0, pr = 0, li = 0, lp = 0, pa = 0, fl = 0;
    logic [2:0] sel = '0;
    if (kind == 0) begin
      pr = 1; li = ph;
    end else if (kind == 1) begin
      lp = ph;
    end else begin
      case (op)
        4'd0: begin rd = 1; lx = ph; end
        4'd1: begin rd = 1; ly = ph; end
        4'd2: wr = 1;
        4'd3: begin pa = 1; lp = ph; end
        4'd4: begin pa = 1; lp = ph & flg; end
        4'd5: begin pa = 1; lp = ph & ~flg; end
        default: begin
          sel = ads[2:0];
          if (ads[2:0] < 3'd6) begin xa = 1; lx = ph; end
          else fl = ph;
        end
      endcase
    end
    return {rd, wr, lx, ly, xa, sel, pr, li, lp, pa, fl};
  endfunction

  task automatic check(string req, logic [12:0] exp_v);
    logic [12:0] got;
    got = {mem_rd, mem_wr, x_load, y_load, x_from_alu, alu_sel,
           prog_rd, ir_load, pc_load, pc_from_ads, flag_load};
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp_v);
    end
  endtask

  function automatic string tag_for(logic [3:0] op);
    if (op < 4'd2) return "R5";
    if (op < 4'd4) return "R6";
    if (op < 4'd6) return "R7";
    return "R8";
  endfunction

  // Called one ns after the negedge that opens fetch step one.
  task automatic run_instr(logic [3:0] op, logic [7:0] ads, bit scramble);
    bit f;
    string t;
    ir_op = op; ir_ads = ads; alu_flag = 1'($urandom);
    #1 check("R3", expect_word(0, 0, op, ads, 0));
    @(negedge clk); #1 check("R3", expect_word(0, 1, op, ads, 0));
    @(negedge clk); #1 check("R4", expect_word(1, 0, op, ads, 0));
    @(negedge clk); #1 check("R4", expect_word(1, 1, op, ads, 0));
    if (is_valid(op, ads)) begin
      t = scramble ? "R11" : tag_for(op);
      @(negedge clk);
      if (scramble) begin ir_op = 4'($urandom); ir_ads = 8'($urandom); end
      f = 1'($urandom); alu_flag = f;
      #1 check(t, expect_word(2, 0, op, ads, f));
      check("R2", expect_word(2, 0, op, ads, f));
      @(negedge clk);
      f = 1'($urandom); alu_flag = f;
      #1 check(t, expect_word(2, 1, op, ads, f));
    end
    @(negedge clk);
    #1 check(is_valid(op, ads) ? "R9" : "R10", expect_word(0, 0, op, ads, 0));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 check("R1", expect_word(0, 0, 0, 0, 0));
    for (int op = 0; op < 16; op++) run_instr(4'(op), 8'd0, 0);
    for (int k = 0; k < 8; k++) run_instr(4'd6, 8'(k), 0);
    run_instr(4'd6, 8'd8, 0);
    run_instr(4'd6, 8'd255, 0);
    for (int i = 0; i < 6; i++) begin
      run_instr(4'd4, 8'd17, 0);
      run_instr(4'd5, 8'd42, 0);
    end
    // reset during a routine step: R1
    ir_op = 4'd0; ir_ads = 8'd0;
    repeat (4) @(negedge clk);
    #1 check("R5", expect_word(2, 0, 4'd0, 8'd0, 0));
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 check("R1", expect_word(0, 0, 0, 0, 0));
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op;
      logic [7:0] ads;
      op = 4'($urandom_range(0, 7));
      ads = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 7));
      run_instr(op, ads, 1'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule